// File: doc/BRIEF.md
# Fast blank source switcher

This block merges two pixel streams that arrive in lock-step, one decoded from composite video and one derived from an RGB input, into a single output stream. The choice between them, made pixel by pixel, follows a fast blank control signal that is sampled eight times per converter clock. The block finds where the fast blank edge falls within a pixel. It moves that edge later by a programmable number of eighth-clock steps, and earlier or later by a signed number of whole pixels. On the pixel where the edge lands, the block outputs a weighted mix of the two sources instead of switching hard.

A manual mode overrides the fast blank signal with a fixed choice of source. All settings arrive as plain input ports and are registered inside the block. The video paths and the decision path share a base latency of four pixels. A negative pixel offset is met by taking the decision from an earlier point in the pipeline.

Top module: `fb_source_switcher`

## Requirements
- R1: When rst_n is low at a rising edge, out_pix and out_alpha become 0, and the registered copies of man_en, man_sel, phase_adj and pix_dly become 0.
- R2: In automatic mode with phase_adj=0 and pix_dly=0, the pixel pair presented in cycle n leaves in cycle n+4. Its weight alpha is the number of set bits in fb_phases of cycle n. Bit 0 is the earliest eighth-phase, and a 1 selects RGB.
- R3: out_alpha carries the weight used, from 0 to 8, and out_pix = floor((alpha*rgb_pix + (8-alpha)*cvbs_pix + 4) / 8).
- R4: With f = phase_adj[2:0], the fast blank seen at phase j of cycle m is fb_phases[j-f] of cycle m when j >= f, and bit 8+j-f of cycle m-1 otherwise. Alpha counts these eight shifted samples.
- R5: phase_adj[3] = 1 adds one whole pixel of delay on top of pix_dly, so a larger phase_adj never moves the transition earlier.
- R6: pix_dly is a 3-bit two's complement value from -4 to +3. With d = pix_dly + phase_adj[3], the weight for the pixel pair of cycle n comes from the fast blank of cycle n-d.
- R7: d is clamped below at -3 (one less than the base latency), so pix_dly = -4 with phase_adj[3] = 0 behaves like d = -3.
- R8: With man_en = 1, the fast blank input is ignored. man_sel = 1 gives alpha 8 and out_pix = rgb_pix, and man_sel = 0 gives alpha 0 and out_pix = cvbs_pix, on every pixel.
- R9: With man_en = 0, man_sel has no effect on either output.
- R10: A change to man_en or man_sel presented in cycle c first governs the output observed in cycle c+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fb_phases | input | 8 | Fast blank samples for this clock, bit 0 earliest, 1 = RGB |
| cvbs_pix | input | PIX_W | Composite-decoded pixel |
| rgb_pix | input | PIX_W | RGB-derived pixel |
| man_en | input | 1 | 1 = manual source choice, 0 = follow fast blank |
| man_sel | input | 1 | Manual choice: 1 = RGB, 0 = composite |
| phase_adj | input | 4 | Fast blank delay in eighth-clock steps |
| pix_dly | input | 3 | Signed whole-pixel decision offset |
| out_pix | output | PIX_W | Selected or blended pixel |
| out_alpha | output | 4 | RGB weight applied to out_pix, 0 to 8 |

## Verification
The pixel pair driven in cycle n is expected in cycle n+4. Its weight comes from the fast blank of cycle n-d, resolved with the shifted eighth-phase window of that cycle and its predecessor. Every setting of phase_adj and pix_dly is swept. The bench holds each setting steady and compares only after fourteen cycles, which is longer than the deepest history tap plus the output stage, so no comparison mixes two settings. The manual-mode latency of R10 is checked cycle by cycle: the old source is expected one cycle after the change and the new source two cycles after it.

// File: rtl/fb_sw_pkg.sv
// Shared constants and helpers for the fast blank source switcher.
// Assumes eight fast blank samples per pixel clock.
package fb_sw_pkg;
    localparam int FB_PHASES  = 8;
    localparam int FB_FRAC_W  = $clog2(FB_PHASES);
    localparam int FB_ALPHA_W = $clog2(FB_PHASES + 1);
    localparam int FB_ADJ_W   = FB_FRAC_W + 1;

    typedef logic [FB_ALPHA_W-1:0] alpha_t;
endpackage

// File: rtl/fb_edge_resolver.sv
// Resolves the sub-clock fast blank position. It shifts the sample stream
// later by a fractional phase count, then counts the RGB-selecting phases
// in the current clock. Assumes fb_in bit 0 is the earliest phase.
module fb_edge_resolver
    import fb_sw_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [FB_PHASES-1:0] fb_in,
    input  logic [FB_FRAC_W-1:0] frac,
    output alpha_t               alpha
);
    localparam int WIN_W = 2 * FB_PHASES;

    logic [FB_PHASES-1:0] fb_prev;
    logic [WIN_W-1:0]     win_sh;
    logic [FB_PHASES-1:0] eff;

    // Hold the previous clock's samples so a delayed edge can reach back.
    always_ff @(posedge clk) begin
        if (!rst_n) fb_prev <= '0;
        else        fb_prev <= fb_in;
    end

    // Shift the two-clock window later by frac phases and keep the current slot.
    always_comb begin
        win_sh = {fb_in, fb_prev} << frac;
        eff    = win_sh[WIN_W-1:FB_PHASES];
    end

    // Count RGB-selecting phases to form the blend weight.
    always_comb begin
        alpha = '0;
        for (int j = 0; j < FB_PHASES; j++) begin
            alpha = alpha + alpha_t'(eff[j]);
        end
    end

    // R4: with RGB held across both clocks, every shift yields full weight.
    p_full_rgb_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((&fb_in) && (&fb_prev)) |-> (alpha == alpha_t'(FB_PHASES)));

    // R4: with composite held across both clocks, every shift yields zero.
    p_no_rgb_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((fb_in == '0) && (fb_prev == '0)) |-> (alpha == '0));
endmodule

// File: rtl/fb_decision_delay.sv
// Keeps a history of blend weights and picks the one whose age matches
// the base latency plus the signed pixel offset plus the phase spill.
// Ages below zero are clamped to the current weight.
module fb_decision_delay
    import fb_sw_pkg::*;
#(
    parameter int LAT   = 4,
    parameter int DLY_W = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  alpha_t                  alpha_in,
    input  logic signed [DLY_W-1:0] dly,
    input  logic                    spill,
    output alpha_t                  alpha_sel
);
    localparam int AGE_BASE = LAT - 1;
    localparam int AGE_MAX  = AGE_BASE + (2 ** (DLY_W - 1)) - 1 + 1;

    alpha_t hist [1:AGE_MAX];
    int     age;

    // Shift the weight history one pixel per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 1; i <= AGE_MAX; i++) hist[i] <= '0;
        end else begin
            hist[1] <= alpha_in;
            for (int i = 2; i <= AGE_MAX; i++) hist[i] <= hist[i-1];
        end
    end

    // Form the requested age and clamp it at the newest available weight.
    always_comb begin
        age = AGE_BASE + int'(dly) + int'(spill);
        if (age < 0) age = 0;
    end

    // Pick the weight of the requested age.
    always_comb begin
        alpha_sel = alpha_in;
        for (int i = 1; i <= AGE_MAX; i++) begin
            if (age == i) alpha_sel = hist[i];
        end
    end
endmodule

// File: rtl/fb_video_delay.sv
// Fixed-depth pixel delay line that aligns a video path with the decision path.
// Assumes STAGES >= 1.
module fb_video_delay #(
    parameter int W      = 8,
    parameter int STAGES = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stg [1:STAGES];

    // First stage captures the incoming pixel.
    always_ff @(posedge clk) begin
        if (!rst_n) stg[1] <= '0;
        else        stg[1] <= din;
    end

    for (genvar s = 2; s <= STAGES; s++) begin : g_stage
        // Each later stage forwards the pixel one clock further.
        always_ff @(posedge clk) begin
            if (!rst_n) stg[s] <= '0;
            else        stg[s] <= stg[s-1];
        end
    end

    assign dout = stg[STAGES];
endmodule

// File: rtl/fb_blend_out.sv
// Output stage: applies the manual override or the automatic weight and
// registers the rounded weighted mix of the two aligned pixels.
module fb_blend_out
    import fb_sw_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] rgb_in,
    input  logic [W-1:0] cvbs_in,
    input  alpha_t       alpha_auto,
    input  logic         man_en,
    input  logic         man_sel,
    output logic [W-1:0] out_pix,
    output alpha_t       out_alpha
);
    localparam int ACC_W = W + FB_ALPHA_W;
    localparam int RND   = FB_PHASES / 2;

    alpha_t           a_use;
    logic [ACC_W-1:0] acc;
    logic [W-1:0]     mix;
    logic [W-1:0]     lo;
    logic [W-1:0]     hi;

    // Replace the weight with an end value in manual mode.
    always_comb begin
        if (man_en) a_use = man_sel ? alpha_t'(FB_PHASES) : '0;
        else        a_use = alpha_auto;
    end

    // Weighted sum with round-half-up, then divide by the phase count.
    always_comb begin
        acc = ACC_W'(a_use) * ACC_W'(rgb_in)
            + ACC_W'(alpha_t'(FB_PHASES) - a_use) * ACC_W'(cvbs_in)
            + ACC_W'(RND);
        mix = acc[FB_FRAC_W +: W];
    end

    // Bounds of the two sources, used by the range check below.
    always_comb begin
        lo = (rgb_in < cvbs_in) ? rgb_in : cvbs_in;
        hi = (rgb_in < cvbs_in) ? cvbs_in : rgb_in;
    end

    // Register the output pixel and the weight that produced it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_pix   <= '0;
            out_alpha <= '0;
        end else begin
            out_pix   <= mix;
            out_alpha <= a_use;
        end
    end

    // R8: a manual RGB choice passes the RGB pixel through unchanged.
    p_manual_rgb_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (man_en && man_sel) |=>
        ((out_alpha == alpha_t'(FB_PHASES)) && (out_pix == $past(rgb_in))));

    // R8: a manual composite choice passes the composite pixel through.
    p_manual_cvbs_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (man_en && !man_sel) |=> ((out_alpha == '0) && (out_pix == $past(cvbs_in))));

    // R3: a blended pixel never leaves the range spanned by its two sources.
    p_blend_bounds_r3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((out_pix >= $past(lo)) && (out_pix <= $past(hi))));

    // R3: the reported weight never exceeds the full scale.
    p_alpha_scale_r3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (out_alpha <= alpha_t'(FB_PHASES)));
endmodule

// File: rtl/fb_source_switcher.sv
// Top level of the fast blank source switcher. It registers the settings,
// resolves the fast blank edge, delays the decision and both video paths
// to a common latency of LAT pixels, and blends them on the edge pixel.
// Assumes both pixel streams and the fast blank samples are clock-aligned.
module fb_source_switcher
    import fb_sw_pkg::*;
#(
    parameter int PIX_W = 8,
    parameter int LAT   = 4,
    parameter int DLY_W = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [FB_PHASES-1:0]  fb_phases,
    input  logic [PIX_W-1:0]      cvbs_pix,
    input  logic [PIX_W-1:0]      rgb_pix,
    input  logic                  man_en,
    input  logic                  man_sel,
    input  logic [FB_ADJ_W-1:0]   phase_adj,
    input  logic [DLY_W-1:0]      pix_dly,
    output logic [PIX_W-1:0]      out_pix,
    output logic [FB_ALPHA_W-1:0] out_alpha
);
    localparam int VID_STAGES = LAT - 1;

    logic                    cfg_man_en;
    logic                    cfg_man_sel;
    logic [FB_ADJ_W-1:0]     cfg_adj;
    logic signed [DLY_W-1:0] cfg_dly;
    alpha_t                  alpha_now;
    alpha_t                  alpha_sel;
    logic [PIX_W-1:0]        rgb_al;
    logic [PIX_W-1:0]        cvbs_al;

    // Capture the settings so they change only on a clock edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_man_en  <= 1'b0;
            cfg_man_sel <= 1'b0;
            cfg_adj     <= '0;
            cfg_dly     <= '0;
        end else begin
            cfg_man_en  <= man_en;
            cfg_man_sel <= man_sel;
            cfg_adj     <= phase_adj;
            cfg_dly     <= pix_dly;
        end
    end

    fb_edge_resolver u_resolver (
        .clk   (clk),
        .rst_n (rst_n),
        .fb_in (fb_phases),
        .frac  (cfg_adj[FB_FRAC_W-1:0]),
        .alpha (alpha_now)
    );

    fb_decision_delay #(.LAT(LAT), .DLY_W(DLY_W)) u_decision (
        .clk       (clk),
        .rst_n     (rst_n),
        .alpha_in  (alpha_now),
        .dly       (cfg_dly),
        .spill     (cfg_adj[FB_ADJ_W-1]),
        .alpha_sel (alpha_sel)
    );

    fb_video_delay #(.W(PIX_W), .STAGES(VID_STAGES)) u_rgb_dly (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (rgb_pix),
        .dout  (rgb_al)
    );

    fb_video_delay #(.W(PIX_W), .STAGES(VID_STAGES)) u_cvbs_dly (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (cvbs_pix),
        .dout  (cvbs_al)
    );

    fb_blend_out #(.W(PIX_W)) u_blend (
        .clk        (clk),
        .rst_n      (rst_n),
        .rgb_in     (rgb_al),
        .cvbs_in    (cvbs_al),
        .alpha_auto (alpha_sel),
        .man_en     (cfg_man_en),
        .man_sel    (cfg_man_sel),
        .out_pix    (out_pix),
        .out_alpha  (out_alpha)
    );

    // R10: a manual setting seen at the ports reaches the output two edges later.
    p_manual_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (man_en && man_sel) |=> (cfg_man_en |=> (out_alpha == alpha_t'(FB_PHASES))));
endmodule

// File: tb/fb_source_switcher_tb.sv
module fb_source_switcher_tb;
    localparam int W    = 8;
    localparam int NMAX = 8192;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [7:0]   fb_phases = '0;
    logic [W-1:0] cvbs_pix = '0;
    logic [W-1:0] rgb_pix = '0;
    logic         man_en = 1'b0;
    logic         man_sel = 1'b0;
    logic [3:0]   phase_adj = '0;
    logic [2:0]   pix_dly = '0;
    logic [W-1:0] out_pix;
    logic [3:0]   out_alpha;

    fb_source_switcher u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .fb_phases (fb_phases),
        .cvbs_pix  (cvbs_pix),
        .rgb_pix   (rgb_pix),
        .man_en    (man_en),
        .man_sel   (man_sel),
        .phase_adj (phase_adj),
        .pix_dly   (pix_dly),
        .out_pix   (out_pix),
        .out_alpha (out_alpha)
    );

    always #4 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int k = 0;
    bit finished = 1'b0;
    logic [31:0] rng = 32'h1234_5677;
    logic [7:0]   fbh [0:NMAX-1];
    logic [W-1:0] rh  [0:NMAX-1];
    logic [W-1:0] ch  [0:NMAX-1];
    int  cur_pa = 0;
    int  cur_pd = 0;
    bit  cur_me = 1'b0;
    bit  cur_ms = 1'b0;
    bit  toggle_sel = 1'b0;

    function automatic logic [31:0] next_rng(input logic [31:0] s);
        logic [31:0] x = s;
        x = x ^ (x << 13);
        x = x ^ (x >> 17);
        x = x ^ (x << 5);
        return x;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, k);
        end
    endtask

    // Weight of the fast blank of cycle m under fractional shift f (R2, R4).
    function automatic int alpha_of(input int m, input int f);
        int cnt = 0;
        for (int j = 0; j < 8; j++) begin
            if (j >= f) cnt += int'(fbh[m][j-f]);
            else        cnt += int'(fbh[m-1][8+j-f]);
        end
        return cnt;
    endfunction

    // One clock: check the outputs at the falling edge, then drive new inputs.
    task automatic tick(input bit do_chk, input string tag);
        int a;
        int age;
        int n;
        int ep;
        @(negedge clk);
        if (do_chk) begin
            n = k - 4;
            if (cur_me) begin
                a = cur_ms ? 8 : 0;
            end else begin
                age = 3 + cur_pd + ((cur_pa >> 3) & 1);
                if (age < 0) age = 0;
                a = alpha_of(k - 1 - age, cur_pa & 7);
            end
            ep = (a * int'(rh[n]) + (8 - a) * int'(ch[n]) + 4) / 8;
            chk(tag, int'(out_alpha), a);
            chk(tag, int'(out_pix), ep);
        end
        rng = next_rng(rng);
        fbh[k] = rng[7:0];
        rh[k]  = rng[15:8];
        ch[k]  = rng[23:16];
        if (rng[27:24] == 4'd0) fbh[k] = 8'h00;
        if (rng[27:24] == 4'd1) fbh[k] = 8'hFF;
        if (rng[27:24] == 4'd2) fbh[k] = 8'hFF << rng[30:28];
        fb_phases = fbh[k];
        rgb_pix   = rh[k];
        cvbs_pix  = ch[k];
        if (toggle_sel) man_sel = ~man_sel;
        k++;
    endtask

    task automatic run_seg(input int pa, input int pd, input bit me, input bit ms,
                           input int ncyc, input string tag);
        cur_pa = pa; cur_pd = pd; cur_me = me; cur_ms = ms;
        phase_adj = 4'(pa);
        pix_dly   = 3'(pd);
        man_en    = me;
        man_sel   = ms;
        for (int i = 0; i < ncyc; i++) tick(i >= 14, tag);
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        string tag;
        // R1: drive busy inputs during reset; the outputs must still read 0.
        fb_phases = 8'hFF; rgb_pix = 8'hFF; cvbs_pix = 8'hA5;
        man_en = 1'b1; man_sel = 1'b1;
        repeat (5) @(negedge clk);
        chk("R1", int'(out_pix), 0);
        chk("R1", int'(out_alpha), 0);
        man_en = 1'b0; man_sel = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", int'(out_pix), 0);
        chk("R1", int'(out_alpha), 0);

        // R2, R4, R5, R6, R7: sweep every phase adjust and pixel offset.
        for (int pa = 0; pa < 16; pa++) begin
            for (int pd = -4; pd <= 3; pd++) begin
                if (pd == -4 && pa < 8)  tag = "R7";
                else if (pa >= 8)        tag = "R5";
                else if (pa != 0)        tag = "R4";
                else if (pd != 0)        tag = "R6";
                else                     tag = "R2";
                run_seg(pa, pd, 1'b0, 1'b0, 24, tag);
            end
        end

        // R3: plain automatic mode, long run of mixed edges.
        run_seg(0, 0, 1'b0, 1'b0, 60, "R3");

        // R8: manual RGB then manual composite.
        run_seg(5, 2, 1'b1, 1'b1, 30, "R8");
        run_seg(5, 2, 1'b1, 1'b0, 30, "R8");

        // R9: man_sel toggles every clock in automatic mode.
        toggle_sel = 1'b1;
        run_seg(3, -1, 1'b0, 1'b0, 40, "R9");
        toggle_sel = 1'b0;

        // R10: switch manual RGB to composite, check the cycle it takes effect.
        run_seg(0, 0, 1'b1, 1'b1, 20, "R8");
        man_sel = 1'b0;
        tick(1'b1, "R10");
        cur_ms = 1'b0;
        tick(1'b1, "R10");
        tick(1'b1, "R10");

        finished = 1'b1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule